// File: doc/BRIEF.md
# Multiplexed Display Scanner with Leading-Zero Blanking

This block drives a time-multiplexed numeric display from a bank of held BCD digits. It selects one digit at a time, starting at the most significant position and ending at the least significant, then starts over. For each digit it presents three things: the 4-bit BCD value, a seven-segment pattern and a one-hot strobe for that digit position. An external latch can use each strobe as its enable to recover the digits from the shared BCD bus.

A scan-enable input advances the scan. Every digit time spans four enabled clocks. The strobe is asserted only in the middle two of those clocks, so both of its edges fall inside the window where the BCD value is steady. A blanking flip-flop hides leading zeros. The flip-flop is armed at the start of every scan. It is cleared by a nonzero digit or by the decimal-point input. It is overridden at the least significant digit and whenever the overflow status is high. A scan-reset input is first passed through a synchronizer. While it is active, the scan is parked on the most significant digit and the display is kept dark. Lamp test lights every segment.

Top module: `disp_scanner`

## Requirements
- R1: While rst_n is low, and until scan_rst low has passed the two-stage synchronizer, strobe_o is all zero, blank_o is 1 and bcd_o shows the most significant digit, digits_i[4*NDIG-1 -: 4].
- R2: Digit k is digits_i[4k+3:4k], and position NDIG-1 is the most significant. The scan visits the positions from NDIG-1 down to 0 and then returns to NDIG-1. The position changes after four clocks in which scan_en is high. Clocks with scan_en low change nothing.
- R3: The digit-time phase counts 0 to 3 on enabled clocks. strobe_o[k] is 1 only while position k is selected and the phase is 1 or 2, and at most one strobe bit is ever high. bcd_o stays equal to the selected digit through all four phases.
- R4: scan_rst goes through two flip-flops. From the second clock edge after scan_rst rises, the phase is 0, the position is NDIG-1, strobe_o is 0 and blank_o is 1. Scanning resumes from that state on the second edge after scan_rst falls.
- R5: Blanking is armed at the start of every scan. blank_o stays 1 while the selected digit is 0, until some digit in that scan clears it.
- R6: dp_i high on an enabled clock unblanks the current digit. All later digits of the same scan stay unblanked.
- R7: The least significant digit (position 0) is never blanked.
- R8: While ovf_i is high, blank_o is 0 outside scan reset.
- R9: seg_o bit 0 is segment a and bit 6 is segment g. Digits 0 to 9 give 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F (hex).
- R10: BCD codes 10 to 15 give seg_o = 0.
- R11: lamp_i high forces seg_o = 7F in every state.
- R12: With blank_o high and lamp_i low, seg_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| scan_en | input | 1 | Scan clock enable; one phase step per high clock |
| scan_rst | input | 1 | Park scan on the most significant digit (asynchronous, synchronized inside) |
| dp_i | input | 1 | Decimal point for the current digit; releases blanking |
| ovf_i | input | 1 | Overflow status; unblanks the display |
| lamp_i | input | 1 | Lamp test; all segments on |
| digits_i | input | 4*NDIG | Held BCD digits, digit k at bits 4k+3:4k |
| bcd_o | output | 4 | BCD value of the selected digit |
| seg_o | output | 7 | Segment pattern, bit 0 = a to bit 6 = g |
| blank_o | output | 1 | Display blanked for this digit |
| strobe_o | output | NDIG | One-hot digit strobe |

## Verification
The hardest case to reach is scan reset changing in the middle of a digit time while scan_en is only partly active. The two-stage synchronizer and the phase counter then interact in ways that a clean start never produces. The stimulus pulses scan_rst at pseudo-random points while scan_en follows a sparse random pattern. A behavioural model with its own synchronizer queue predicts every clock. Leading-zero runs are cut short by a decimal point placed on a mid-scan digit and by overflow switched on mid-scan.

// File: rtl/disp_scan_pkg.sv
package disp_scan_pkg;
  localparam int BCD_W = 4;
  localparam int SEG_W = 7;

  // segment order: bit0 = a ... bit6 = g
  function automatic logic [SEG_W-1:0] seg7_of(input logic [BCD_W-1:0] v);
    logic [SEG_W-1:0] s;
    case (v)
      4'd0: s = 7'h3F;
      4'd1: s = 7'h06;
      4'd2: s = 7'h5B;
      4'd3: s = 7'h4F;
      4'd4: s = 7'h66;
      4'd5: s = 7'h6D;
      4'd6: s = 7'h7D;
      4'd7: s = 7'h07;
      4'd8: s = 7'h7F;
      4'd9: s = 7'h6F;
      default: s = '0;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/dsc_scan_seq.sv
module dsc_scan_seq #(
  parameter int NDIG   = 8,
  parameter int PHASES = 4,
  localparam int DIG_W = $clog2(NDIG),
  localparam int PH_W  = $clog2(PHASES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scan_en,
  input  logic             scan_rst,
  output logic             hold_o,
  output logic [DIG_W-1:0] idx_o,
  output logic [PH_W-1:0]  phase_o,
  output logic             digit_end_o
);
  localparam logic [DIG_W-1:0] MSD_IDX  = DIG_W'(NDIG - 1);
  localparam logic [PH_W-1:0]  LAST_PH  = PH_W'(PHASES - 1);

  logic             sync1_q, sync2_q;
  logic [DIG_W-1:0] idx_q, idx_d;
  logic [PH_W-1:0]  ph_q, ph_d;

  // two-stage synchronizer for scan reset; reset parks the scan
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
    end else begin
      sync1_q <= scan_rst;
      sync2_q <= sync1_q;
    end
  end

  assign digit_end_o = !sync2_q && scan_en && (ph_q == LAST_PH);

  always_comb begin
    idx_d = idx_q;
    ph_d  = ph_q;
    if (sync2_q) begin
      idx_d = MSD_IDX;
      ph_d  = '0;
    end else if (scan_en) begin
      ph_d = (ph_q == LAST_PH) ? '0 : ph_q + 1'b1;
      if (ph_q == LAST_PH)
        idx_d = (idx_q == '0) ? MSD_IDX : idx_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= MSD_IDX;
      ph_q  <= '0;
    end else begin
      idx_q <= idx_d;
      ph_q  <= ph_d;
    end
  end

  assign hold_o  = sync2_q;
  assign idx_o   = idx_q;
  assign phase_o = ph_q;
endmodule

// File: rtl/dsc_blank_ctl.sv
module dsc_blank_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic scan_en,
  input  logic digit_end,
  input  logic at_lsd,
  input  logic digit_zero,
  input  logic dp,
  input  logic ovf,
  output logic blank_o
);
  logic armed_q, armed_d;
  logic live;

  // still suppressing: armed, zero digit, nothing forcing it open
  assign live = armed_q && digit_zero && !dp && !at_lsd && !ovf;

  always_comb begin
    armed_d = armed_q;
    if (hold)
      armed_d = 1'b1;
    else if (scan_en)
      armed_d = (digit_end && at_lsd) ? 1'b1 : live;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b1;
    else        armed_q <= armed_d;
  end

  assign blank_o = hold || live;
endmodule

// File: rtl/dsc_seg_drv.sv
module dsc_seg_drv
  import disp_scan_pkg::*;
(
  input  logic [BCD_W-1:0] bcd,
  input  logic             blank,
  input  logic             lamp,
  output logic [SEG_W-1:0] seg_o
);
  always_comb begin
    if (lamp)       seg_o = '1;
    else if (blank) seg_o = '0;
    else            seg_o = seg7_of(bcd);
  end
endmodule

// File: rtl/disp_scanner.sv
module disp_scanner
  import disp_scan_pkg::*;
#(
  parameter int NDIG   = 8,
  parameter int PHASES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scan_en,
  input  logic                  scan_rst,
  input  logic                  dp_i,
  input  logic                  ovf_i,
  input  logic                  lamp_i,
  input  logic [BCD_W*NDIG-1:0] digits_i,
  output logic [BCD_W-1:0]      bcd_o,
  output logic [SEG_W-1:0]      seg_o,
  output logic                  blank_o,
  output logic [NDIG-1:0]       strobe_o
);
  localparam int DIG_W = $clog2(NDIG);
  localparam int PH_W  = $clog2(PHASES);
  localparam logic [PH_W-1:0] STB_FIRST = PH_W'(1);
  localparam logic [PH_W-1:0] STB_LAST  = PH_W'(PHASES - 2);

  logic             hold;
  logic [DIG_W-1:0] idx;
  logic [PH_W-1:0]  phase;
  logic             digit_end;
  logic             stb_win;

  dsc_scan_seq #(.NDIG(NDIG), .PHASES(PHASES)) u_seq (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .scan_rst(scan_rst),
    .hold_o(hold), .idx_o(idx), .phase_o(phase), .digit_end_o(digit_end)
  );

  assign bcd_o = digits_i[BCD_W*idx +: BCD_W];

  dsc_blank_ctl u_blank (
    .clk(clk), .rst_n(rst_n), .hold(hold), .scan_en(scan_en),
    .digit_end(digit_end), .at_lsd(idx == '0), .digit_zero(bcd_o == '0),
    .dp(dp_i), .ovf(ovf_i), .blank_o(blank_o)
  );

  dsc_seg_drv u_seg (
    .bcd(bcd_o), .blank(blank_o), .lamp(lamp_i), .seg_o(seg_o)
  );

  assign stb_win = !hold && (phase >= STB_FIRST) && (phase <= STB_LAST);

  for (genvar k = 0; k < NDIG; k++) begin : g_stb
    assign strobe_o[k] = stb_win && (idx == DIG_W'(k));
  end
endmodule

// File: rtl/disp_scanner_chk.sv
module disp_scanner_chk #(
  parameter int NDIG = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            scan_rst,
  input logic            ovf_i,
  input logic            lamp_i,
  input logic [3:0]      bcd_o,
  input logic [6:0]      seg_o,
  input logic            blank_o,
  input logic [NDIG-1:0] strobe_o
);
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 1'b1;
  end

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobe_o)); // R3
  AST_LAMP_ALL_ON: assert property (@(posedge clk) disable iff (!rst_n)
    lamp_i |-> seg_o == 7'h7F); // R11
  AST_BLANK_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_o && !lamp_i) |-> seg_o == 7'h00); // R12
  AST_LSD_LIT: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o[0] |-> !blank_o); // R7
  AST_OVF_LIT: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_i && (strobe_o != '0)) |-> !blank_o); // R8
  AST_BAD_CODE_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (bcd_o > 4'd9 && !lamp_i) |-> seg_o == 7'h00); // R10
  AST_SCAN_RST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd2 && $past(scan_rst) && $past(scan_rst, 2))
      |-> (strobe_o == '0 && blank_o)); // R4
endmodule

bind disp_scanner disp_scanner_chk #(.NDIG(NDIG)) u_chk (
  .clk(clk), .rst_n(rst_n), .scan_rst(scan_rst), .ovf_i(ovf_i),
  .lamp_i(lamp_i), .bcd_o(bcd_o), .seg_o(seg_o), .blank_o(blank_o),
  .strobe_o(strobe_o)
);

// File: tb/tb_disp_scanner.sv
module tb_disp_scanner;
  localparam int CLK_PERIOD = 10;
  localparam int ND = 8;

  logic clk = 1'b0;
  logic rst_n, scan_en, scan_rst, dp_i, ovf_i, lamp_i;
  logic [4*ND-1:0] digits_i;
  logic [3:0] bcd_o;
  logic [6:0] seg_o;
  logic blank_o;
  logic [ND-1:0] strobe_o;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  string tag = "R1";

  // model state
  int m_s1, m_s2, m_ph, m_ix, m_arm;

  disp_scanner dut (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .scan_rst(scan_rst),
    .dp_i(dp_i), .ovf_i(ovf_i), .lamp_i(lamp_i), .digits_i(digits_i),
    .bcd_o(bcd_o), .seg_o(seg_o), .blank_o(blank_o), .strobe_o(strobe_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [6:0] font(input int v);
    case (v)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
      4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
      8: return 7'h7F; 9: return 7'h6F;
      default: return 7'h00;
    endcase
  endfunction

  function automatic int dig(input int k);
    return int'(digits_i[4*k +: 4]);
  endfunction

  function automatic bit m_live();
    return m_arm != 0 && dig(m_ix) == 0 && !dp_i && m_ix != 0 && !ovf_i;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_s1 = 1; m_s2 = 1; m_ph = 0; m_ix = ND-1; m_arm = 1;
    end else begin
      if (m_s2 != 0) begin
        m_ph = 0; m_ix = ND-1; m_arm = 1;
      end else if (scan_en) begin
        m_arm = (m_ph == 3 && m_ix == 0) ? 1 : int'(m_live());
        if (m_ph == 3) m_ix = (m_ix == 0) ? ND-1 : m_ix - 1;
        m_ph = (m_ph + 1) % 4;
      end
      m_s2 = m_s1;
      m_s1 = int'(scan_rst);
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // compare all outputs against the model, called away from the clock edge
  task automatic compare();
    bit hold, bl;
    int eb, es, eseg;
    hold = (m_s2 != 0);
    eb = dig(m_ix);
    bl = hold || m_live();
    es = (!hold && (m_ph == 1 || m_ph == 2)) ? (1 << m_ix) : 0;
    eseg = lamp_i ? 'h7F : (bl ? 0 : int'(font(eb)));
    chk("bcd", int'(bcd_o), eb);
    chk("strobe", int'(strobe_o), es);
    chk("blank", int'(blank_o), int'(bl));
    chk("seg", int'(seg_o), eseg);
  endtask

  task automatic run(input int n, input int en_mode);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
      case (en_mode)
        0: scan_en = 1'b1;
        1: scan_en = (i % 3 == 0);
        default: scan_en = ($urandom % 4) == 0;
      endcase
    end
  endtask

  initial begin
    rst_n = 1'b0; scan_en = 1'b0; scan_rst = 1'b0; dp_i = 1'b0;
    ovf_i = 1'b0; lamp_i = 1'b0; digits_i = 32'h0012_0345;
    repeat (3) @(negedge clk);
    // R1 reset state
    tag = "R1";
    chk("reset strobe", int'(strobe_o), 0);
    chk("reset blank", int'(blank_o), 1);
    chk("reset bcd", int'(bcd_o), 0);
    rst_n = 1'b1;
    run(3, 0);
    // R2 scan order, full enable; R5 leading zeros blanked
    tag = "R2"; run(80, 0);
    tag = "R5"; digits_i = 32'h0000_7000; run(70, 0);
    // R3 strobes with sparse enable
    tag = "R3"; digits_i = 32'h9876_5432; run(150, 1);
    // R7 all zeros: only LSD lit
    tag = "R7"; digits_i = 32'h0000_0000; run(70, 0);
    // R6 decimal point raised on one mid-scan digit
    tag = "R6";
    for (int s = 0; s < 3; s++) begin
      for (int c = 0; c < 32; c++) begin
        @(negedge clk);
        compare();
        scan_en = 1'b1;
        dp_i = (c >= 11 && c < 15);
      end
    end
    dp_i = 1'b0;
    // R8 overflow turned on mid-scan
    tag = "R8"; run(13, 0); ovf_i = 1'b1; run(50, 0); ovf_i = 1'b0;
    // R9 every digit value
    tag = "R9"; digits_i = 32'h1357_9246; run(40, 0);
    digits_i = 32'h8000_0010; run(40, 0);
    // R10 illegal codes
    tag = "R10"; digits_i = 32'hABCD_EF0A; run(40, 0);
    // R11 lamp test, including during scan reset
    tag = "R11"; lamp_i = 1'b1; digits_i = 32'h0000_0F01; run(40, 0);
    scan_rst = 1'b1; run(6, 0); scan_rst = 1'b0; run(10, 0); lamp_i = 1'b0;
    // R12 blanked digits dark
    tag = "R12"; digits_i = 32'h0000_0005; run(40, 2);
    // R4 scan reset pulses at scattered points with random enable
    tag = "R4"; digits_i = 32'h0305_0070;
    for (int p = 0; p < 40; p++) begin
      run(($urandom % 23) + 1, 2);
      scan_rst = 1'b1;
      run(($urandom % 5) + 1, 2);
      scan_rst = 1'b0;
      dp_i = ($urandom % 5) == 0;
      ovf_i = ($urandom % 9) == 0;
    end
    dp_i = 1'b0; ovf_i = 1'b0;
    run(60, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule